// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Access Controller

This block sits between a synchronous on-chip requester and an external 1M x 16 pseudo-static RAM that has an asynchronous SRAM-style interface. It accepts one single-word read or write at a time, described by an address, write data, a two-bit byte-lane mask and a direction flag. It then sequences the memory's chip enable, write enable, output enable, the two byte-lane enables, the 20-bit address and the shared 16-bit data bus. Every interval is a parameter counted in system clock cycles.

After reset the controller waits out a power-up hold-off. During that time chip enable stays high and no request is taken. Each access starts with a setup cycle in which only the address is driven. Chip enable then goes low for a fixed access window, so reads are controlled by chip enable with the address already settled. A deselect gap follows before the next request is accepted. Read data is captured in the last cycle of the window and returned with a one-cycle valid pulse. A write reports completion with a one-cycle done pulse at the same point.

Top module: `psram_async_ctrl`

## Requirements
- R1: After reset `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high and `req_ready` is low. `req_ready` stays low, with chip enable high, for at least PWRUP_CYC cycles, and rises no later than PWRUP_CYC+2 cycles after reset is released.
- R2: The sleep control `mem_zz_n` is high at all times.
- R3: Before every access the address is driven for at least one cycle with chip enable high. It does not change while chip enable is low.
- R4: Every access holds chip enable low for exactly ACC_CYC cycles, which is always less than CE_MAX_CYC.
- R5: Between two accesses chip enable stays high for at least DESEL_CYC+2 cycles.
- R6: During a read, output enable is low and write enable is high while chip enable is low. During a write, write enable is low and output enable is high. Neither strobe is low while chip enable is high.
- R7: Mask bit 0 selects the lower lane, data bits 7:0, through `mem_lb_n`. Mask bit 1 selects the upper lane, data bits 15:8, through `mem_ub_n`. A lane enable is low only while chip enable is low and its mask bit is 1, so a write changes only the selected lanes.
- R8: The controller drives `mem_dq` only while write enable is low. It never drives the bus in the setup cycle before output enable falls.
- R9: A read returns `rd_data` with `rd_valid` high for exactly one cycle, ACC_CYC+1 cycles after the accepting clock edge. Lanes whose mask bit is 0 read as zero.
- R10: A write signals `wr_done` high for exactly one cycle, ACC_CYC+1 cycles after the accepting clock edge.
- R11: A request is accepted only on a clock edge where `req_ready` is high. `req_ready` is low, and `req_valid` is ignored, from acceptance until the deselect gap ends.
- R12: A request with an all-zero mask runs a full timed access with both lane enables high. It changes no stored data, and as a read it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, released once supply is stable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane mask, bit 0 lower lane, bit 1 upper lane |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 16 | Read data, unselected lanes zero |
| wr_done | output | 1 | One-cycle write-completion strobe |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_zz_n | output | 1 | Memory sleep control, held high |
| mem_addr | output | 20 | Memory address |
| mem_dq | inout | 16 | Memory data bus |

## Verification
The bench runs partial-lane writes followed by full-lane reads, so that a swapped or ignored lane enable shows up as corrupted neighbour bytes. It also uses empty-mask requests, which a faulty design would let through as a write or as a stale read. Back-to-back requests test the deselect gap: a gap that is one cycle short, or a window of the wrong length, shows up as a short chip-enable-high run or a latency off by one. A request held valid while the controller is busy must not leave a second write behind. The bench also measures how long the hold-off lasts after reset, to catch a controller that becomes ready early.

// File: rtl/psram_ctrl_pkg.sv
`timescale 1ns/1ps
package psram_ctrl_pkg;

    // Sequencer phases; the reset phase must encode as zero.
    typedef enum logic [2:0] {
        PH_HOLD  = 3'd0,
        PH_IDLE  = 3'd1,
        PH_SETUP = 3'd2,
        PH_WIN   = 3'd3,
        PH_GAP   = 3'd4
    } seq_phase_e;

endpackage

// File: rtl/psram_holdoff.sv
`timescale 1ns/1ps
// Counts supply-settle cycles after reset and raises done once reached.
module psram_holdoff #(
    parameter int PWRUP_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int HW = $clog2(PWRUP_CYC + 1);
    localparam logic [HW-1:0] LIMIT = HW'(PWRUP_CYC);

    logic [HW-1:0] tick_d, tick_q;

    always_comb begin
        tick_d = tick_q;
        if (tick_q != LIMIT) begin
            tick_d = tick_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_d;
        end
    end

    assign done = (tick_q == LIMIT);
endmodule

// File: rtl/psram_lane_map.sv
`timescale 1ns/1ps
// Per-lane enable generation and read-lane masking.
module psram_lane_map #(
    parameter int DW = 16
) (
    input  logic [DW/8-1:0] lane_sel,
    input  logic            active,
    input  logic [DW-1:0]   raw_in,
    output logic [DW/8-1:0] lane_en_n,
    output logic [DW-1:0]   kept
);
    localparam int LANES = DW / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en_n[g]   = ~(active & lane_sel[g]);
        assign kept[g*8 +: 8] = lane_sel[g] ? raw_in[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/psram_async_ctrl.sv
`timescale 1ns/1ps
// Single-word access sequencer for an asynchronous pseudo-static RAM.
module psram_async_ctrl
    import psram_ctrl_pkg::*;
#(
    parameter int AW         = 20,
    parameter int DW         = 16,
    parameter int PWRUP_CYC  = 20000,
    parameter int ACC_CYC    = 7,
    parameter int DESEL_CYC  = 2,
    parameter int CE_MAX_CYC = 4000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW/8-1:0] req_be,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic            wr_done,
    output logic            mem_ce_n,
    output logic            mem_we_n,
    output logic            mem_oe_n,
    output logic            mem_ub_n,
    output logic            mem_lb_n,
    output logic            mem_zz_n,
    output logic [AW-1:0]   mem_addr,
    inout  wire  [DW-1:0]   mem_dq
);
    localparam int LANES = DW / 8;
    localparam int CMAX  = (ACC_CYC > DESEL_CYC) ? ACC_CYC : DESEL_CYC;
    localparam int CW    = $clog2(CMAX + 1);
    localparam logic [CW-1:0] WIN_LOAD = CW'(ACC_CYC - 1);
    localparam logic [CW-1:0] GAP_LOAD = CW'(DESEL_CYC - 1);

    if (ACC_CYC < 1 || DESEL_CYC < 1 || ACC_CYC >= CE_MAX_CYC || LANES != 2) begin : g_bad_cfg
        $error("psram_async_ctrl: illegal timing or width parameters");
    end

    typedef struct packed {
        seq_phase_e       ph;
        logic [CW-1:0]    cnt;
        logic             is_wr;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [LANES-1:0] lanes;
        logic             ce_n;
        logic             we_n;
        logic             oe_n;
        logic             drv;
        logic             rvalid;
        logic [DW-1:0]    rdata;
        logic             wdone;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             hold_done;
    logic [LANES-1:0] lane_en_n;
    logic [DW-1:0]    rd_kept;
    logic             dq_en;

    psram_holdoff #(.PWRUP_CYC(PWRUP_CYC)) u_holdoff (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (hold_done)
    );

    psram_lane_map #(.DW(DW)) u_lanes (
        .lane_sel  (r_q.lanes),
        .active    (~r_q.ce_n),
        .raw_in    (mem_dq),
        .lane_en_n (lane_en_n),
        .kept      (rd_kept)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        r_d.wdone  = 1'b0;
        unique case (r_q.ph)
            PH_HOLD: begin
                if (hold_done) begin
                    r_d.ph = PH_IDLE;
                end
            end
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.ph    = PH_SETUP;
                    r_d.is_wr = req_write;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.lanes = req_be;
                end
            end
            PH_SETUP: begin
                // Address has been settled for a full cycle; open the window.
                r_d.ph   = PH_WIN;
                r_d.cnt  = WIN_LOAD;
                r_d.ce_n = 1'b0;
                r_d.we_n = ~r_q.is_wr;
                r_d.oe_n = r_q.is_wr;
                r_d.drv  = r_q.is_wr;
            end
            PH_WIN: begin
                if (r_q.cnt == '0) begin
                    r_d.ph   = PH_GAP;
                    r_d.cnt  = GAP_LOAD;
                    r_d.ce_n = 1'b1;
                    r_d.we_n = 1'b1;
                    r_d.oe_n = 1'b1;
                    r_d.drv  = 1'b0;
                    if (r_q.is_wr) begin
                        r_d.wdone = 1'b1;
                    end else begin
                        r_d.rvalid = 1'b1;
                        r_d.rdata  = rd_kept;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            PH_GAP: begin
                if (r_q.cnt == '0) begin
                    r_d.ph = PH_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: begin
                r_d.ph = PH_HOLD;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.ph   <= PH_HOLD;
            r_q.ce_n <= 1'b1;
            r_q.we_n <= 1'b1;
            r_q.oe_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign dq_en     = r_q.drv;
    assign mem_dq    = dq_en ? r_q.wdata : {DW{1'bz}};
    assign req_ready = (r_q.ph == PH_IDLE);
    assign rd_valid  = r_q.rvalid;
    assign rd_data   = r_q.rdata;
    assign wr_done   = r_q.wdone;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_lb_n  = lane_en_n[0];
    assign mem_ub_n  = lane_en_n[LANES-1];
    assign mem_zz_n  = 1'b1;
    assign mem_addr  = r_q.addr;
endmodule

// File: rtl/psram_async_chk.sv
`timescale 1ns/1ps
// Protocol checker attached to the controller.
module psram_async_chk #(
    parameter int AW         = 20,
    parameter int ACC_CYC    = 7,
    parameter int DESEL_CYC  = 2,
    parameter int CE_MAX_CYC = 4000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_ce_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic [AW-1:0] mem_addr,
    input logic          req_ready,
    input logic          rd_valid,
    input logic          wr_done,
    input logic          dq_en
);
    localparam int LW = $clog2(CE_MAX_CYC + 1);
    localparam int HW = $clog2(DESEL_CYC + 3) + 1;

    logic [LW-1:0] lo_cnt_q;
    logic [HW-1:0] hi_cnt_q;
    logic          low_seen_q;
    logic          ready_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt_q     <= '0;
            hi_cnt_q     <= '0;
            low_seen_q   <= 1'b0;
            ready_seen_q <= 1'b0;
        end else begin
            if (!mem_ce_n) begin
                lo_cnt_q   <= (lo_cnt_q == '1) ? lo_cnt_q : lo_cnt_q + 1'b1;
                hi_cnt_q   <= '0;
                low_seen_q <= 1'b1;
            end else begin
                lo_cnt_q <= '0;
                hi_cnt_q <= (hi_cnt_q == '1) ? hi_cnt_q : hi_cnt_q + 1'b1;
            end
            if (req_ready) begin
                ready_seen_q <= 1'b1;
            end
        end
    end

    p_hold_ce_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_seen_q |-> mem_ce_n);
    p_addr_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> $stable(mem_addr));
    p_win_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (lo_cnt_q < LW'(ACC_CYC)));
    p_ce_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt_q < LW'(CE_MAX_CYC));
    p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ce_n) && low_seen_q) |-> (hi_cnt_q >= HW'(DESEL_CYC + 2)));
    p_oe_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));
    p_we_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));
    p_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dq_en |-> !mem_we_n);
    p_rv_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    p_wd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);
    p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !rd_valid && !wr_done));
endmodule

bind psram_async_ctrl psram_async_chk #(
    .AW         (AW),
    .ACC_CYC    (ACC_CYC),
    .DESEL_CYC  (DESEL_CYC),
    .CE_MAX_CYC (CE_MAX_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .wr_done   (wr_done),
    .dq_en     (dq_en)
);

// File: tb/psram_async_ctrl_test.sv
`timescale 1ns/1ps
module psram_async_ctrl_test;
    localparam int AW = 20, DW = 16;
    localparam int PWRUP = 20000, ACC = 7, DESEL = 2, CEMAX = 4000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0] req_be = '0;
    logic req_ready, rd_valid, wr_done;
    logic [DW-1:0] rd_data;
    logic mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_zz_n;
    logic [AW-1:0] mem_addr;
    wire  [DW-1:0] mem_dq;

    int total = 0, bad = 0, cyc = 0;

    always #5 clk = ~clk;

    psram_async_ctrl #(.AW(AW), .DW(DW), .PWRUP_CYC(PWRUP), .ACC_CYC(ACC),
                       .DESEL_CYC(DESEL), .CE_MAX_CYC(CEMAX)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_zz_n(mem_zz_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    // ---------------- memory model ----------------
    logic [DW-1:0] mdl [logic [AW-1:0]];
    logic [DW-1:0] ref_mem [logic [AW-1:0]];
    logic [DW-1:0] mdl_rd = '0;

    function automatic logic [DW-1:0] mdl_get(input logic [AW-1:0] a);
        return mdl.exists(a) ? mdl[a] : '0;
    endfunction

    function automatic logic [DW-1:0] ref_get(input logic [AW-1:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : '0;
    endfunction

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [1:0] be);
        return (old & ~lane_mask(be)) | (nw & lane_mask(be));
    endfunction

    always @(negedge clk) mdl_rd = mdl_get(mem_addr);

    assign mem_dq[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_lb_n) ? mdl_rd[7:0]  : 8'bz;
    assign mem_dq[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_ub_n) ? mdl_rd[15:8] : 8'bz;

    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n) begin
            logic [DW-1:0] t;
            t = mdl_get(mem_addr);
            if (!mem_lb_n) t[7:0]  = mem_dq[7:0];
            if (!mem_ub_n) t[15:8] = mem_dq[15:8];
            mdl[mem_addr] = t;
        end
    end

    // ---------------- check helper ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
            finish_run();
        end
    end

    // ---------------- bus monitor ----------------
    logic cur_wr = 1'b0;
    logic [1:0] cur_be = 2'b00;
    logic prev_ce = 1'b1;
    logic [AW-1:0] prev_addr = '0;
    int lo_run = 0, hi_run = 0;
    bit seen_low = 0, addr_bad = 0, ctl_bad = 0, lane_bad = 0;
    logic [AW-1:0] held_addr;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n) begin
                if (prev_ce) begin
                    if (seen_low) chk(hi_run >= DESEL + 2, "R5", "deselect gap", hi_run, DESEL + 2);
                    chk(mem_addr == prev_addr, "R3", "address settled before enable", mem_addr, prev_addr);
                    chk(mem_zz_n == 1'b1, "R2", "sleep pin high", mem_zz_n, 1);
                    lo_run = 0;
                end else if (mem_addr != prev_addr) begin
                    addr_bad = 1;
                end
                lo_run++;
                if (cur_wr ? !(mem_we_n == 0 && mem_oe_n == 1) : !(mem_we_n == 1 && mem_oe_n == 0))
                    ctl_bad = 1;
                if ((mem_lb_n != ~cur_be[0]) || (mem_ub_n != ~cur_be[1])) lane_bad = 1;
            end else begin
                if (!prev_ce) begin
                    chk(lo_run == ACC, "R4", "enable low length", lo_run, ACC);
                    chk(!addr_bad, "R3", "address stable while enabled", addr_bad, 0);
                    chk(!ctl_bad, "R6", "strobe polarity", ctl_bad, 0);
                    chk(!lane_bad, "R7", "lane enable pattern", lane_bad, 0);
                    addr_bad = 0; ctl_bad = 0; lane_bad = 0;
                    seen_low = 1;
                    hi_run = 0;
                end
                hi_run++;
                if (!mem_oe_n || !mem_we_n || !mem_lb_n || !mem_ub_n) ctl_bad = 1;
            end
            prev_ce = mem_ce_n;
            prev_addr = mem_addr;
        end
    end

    // ---------------- stimulus ----------------
    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [1:0] be, input bit poke);
        logic [DW-1:0] exp;
        int lat;
        exp = ref_get(a) & lane_mask(be);
        @(negedge clk);
        cur_wr = wr; cur_be = be;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (wr) ref_mem[a] = merge(ref_get(a), d, be);
        lat = 0;
        if (poke) begin
            // R11: request held while busy must be ignored
            held_addr = a ^ 20'h00F0F;
            req_write = 1; req_addr = held_addr; req_wdata = 16'hBAD1; req_be = 2'b11;
            repeat (3) begin
                chk(!req_ready, "R11", "ready low while busy", req_ready, 0);
                @(negedge clk); lat++;
            end
        end
        req_valid = 0;
        while (lat < 40) begin
            if (wr ? wr_done : rd_valid) break;
            @(negedge clk); lat++;
        end
        if (wr) begin
            chk(lat == ACC + 1, "R10", "write done latency", lat, ACC + 1);
        end else begin
            chk(lat == ACC + 1, "R9", "read valid latency", lat, ACC + 1);
            chk(rd_data == exp, (be == 2'b00) ? "R12" : "R9", "read data", rd_data, exp);
        end
        @(negedge clk);
        chk(!(wr ? wr_done : rd_valid), wr ? "R10" : "R9", "strobe one cycle", 0, 0);
    endtask

    initial begin
        logic [AW-1:0] pool [6];
        int wait_n;
        bit early_ce;
        pool = '{20'h00000, 20'hFFFFF, 20'h12345, 20'h0ABCD, 20'h80000, 20'h7FFFF};
        void'($urandom(32'd1234));

        repeat (4) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes high in reset",
            {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        chk(!req_ready && !rd_valid && !wr_done, "R1", "no ready in reset", req_ready, 0);
        chk(mem_zz_n == 1'b1, "R2", "sleep pin high in reset", mem_zz_n, 1);
        rst_n = 1;
        wait_n = 0; early_ce = 0;
        while (!req_ready && wait_n < PWRUP + 50) begin
            @(negedge clk); wait_n++;
            if (!mem_ce_n) early_ce = 1;
        end
        chk(wait_n >= PWRUP && wait_n <= PWRUP + 2, "R1", "hold-off length", wait_n, PWRUP);
        chk(!early_ce, "R1", "enable high during hold-off", early_ce, 0);

        // directed: full writes at range ends, partial lanes, empty masks
        access(1, 20'h00000, 16'hA55A, 2'b11, 0);
        access(1, 20'hFFFFF, 16'h1234, 2'b11, 0);
        access(0, 20'h00000, 16'h0, 2'b11, 0);
        access(0, 20'hFFFFF, 16'h0, 2'b11, 0);
        access(1, 20'h00000, 16'hCDEF, 2'b01, 0);   // R7 lower lane only
        access(0, 20'h00000, 16'h0, 2'b11, 0);
        access(1, 20'hFFFFF, 16'h9876, 2'b10, 0);   // R7 upper lane only
        access(0, 20'hFFFFF, 16'h0, 2'b11, 0);
        access(0, 20'hFFFFF, 16'h0, 2'b01, 0);      // R9 masked upper lane reads zero
        access(1, 20'h00000, 16'hFFFF, 2'b00, 0);   // R12 empty-mask write
        access(0, 20'h00000, 16'h0, 2'b11, 0);
        access(0, 20'h00000, 16'h0, 2'b00, 0);      // R12 empty-mask read
        access(0, 20'h12345, 16'h0, 2'b11, 1);      // R11 busy request ignored
        access(0, held_addr, 16'h0, 2'b11, 0);

        // random mix
        for (int i = 0; i < 60; i++) begin
            access($urandom % 2, pool[$urandom % 6], 16'($urandom), 2'($urandom), 0);
        end
        for (int i = 0; i < 6; i++) access(0, pool[i], 16'h0, 2'b11, 0);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule